// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an 8-bit up-counter with a software-visible control register and a reload register, for use by a small processor. It runs in one of three ways. It can count a divided copy of the system clock. It can count edges seen on an external input pin. It can measure how long one pulse on that pin lasts, by counting the divided clock between a start edge and a stop edge. Whenever the count passes its top value, the counter reloads itself from the reload register. The same overflow raises an interrupt request, emits a wake-up strobe and flips a divider output, which can drive a tone generator.

Software writes the control byte and the counter through separate write strobes, and reads both back at any time. Reading the counter carries a side effect: the count step in that same cycle is suppressed, so a program that reads often can lose count events. The external input is asynchronous. It passes through a synchronizer, and its edges are found in the system clock domain.

Top module: `multiTimer`

## Requirements
- R1: After reset the control byte reads 0x00, the counter reads 0x00, and intReq, wakeStrobe and divOut are 0.
- R2: The control byte holds the prescaler select in bits 2..0, the edge select in bit 3, the run bit in bit 4 and the mode in bits 7..6. Bit 5 always reads 0, whatever was written to it.
- R3: With mode 2'b10 (timer) and run = 1, the counter steps once every 2^(n+1) system clocks, where n is the prescaler select. With reload value P, consecutive overflows are therefore (256 − P)·2^(n+1) cycles apart.
- R4: With mode 2'b01 (event) and run = 1, an edge select of 0 counts rising edges of evtIn and ignores falling edges. An edge select of 1 counts falling edges and ignores rising edges. A counted edge changes the counter on the third rising clock edge after evtIn changes.
- R5: With mode 2'b11 (pulse width) and run = 1, counting does not start on the level of evtIn. It starts on a start edge and stops on the next opposite edge. With edge select 1 the start edge is rising; with edge select 0 it is falling. While the measurement runs, the counter steps at the prescaled rate. When the stop edge arrives, hardware clears the run bit and the count then holds.
- R6: In timer and event modes the run bit changes only through a control write. It stays set across overflows.
- R7: When the counter steps from 0xFF, it loads the reload value instead. wakeStrobe pulses high for one cycle as the reload appears. intReq pulses in the same cycle only if intEnable was 1 in the overflow cycle.
- R8: A counter write while run = 0 sets both the reload register and the counter. A counter write while run = 1 sets only the reload register, and the counter keeps its value.
- R9: In a cycle with cntRdEn = 1, the counter does not step, so a count event in that cycle is lost.
- R10: divOut toggles on every overflow and holds otherwise.
- R11: With mode 2'b00 the counter holds its value even when the run bit is set.
- R12: If a counter write and an overflow fall in the same cycle, the counter reloads with the reload value held before that write. The written value is used from the next overflow on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Write strobe for the control byte |
| ctlWrData | input | 8 | Control byte write data |
| cntWrEn | input | 1 | Write strobe for the counter and reload register |
| cntWrData | input | CNT_W | Counter/reload write data |
| cntRdEn | input | 1 | Counter read strobe; suppresses a count step in its cycle |
| evtIn | input | 1 | Asynchronous external event/pulse input |
| intEnable | input | 1 | Interrupt enable gating intReq |
| ctlRdData | output | 8 | Control byte read data |
| cntRdData | output | CNT_W | Current counter value |
| intReq | output | 1 | One-cycle interrupt request on overflow |
| wakeStrobe | output | 1 | One-cycle wake-up pulse on overflow |
| divOut | output | 1 | Divider output, toggles per overflow |

## Verification
Two pairs of functions can meet in a single cycle. The first pair is a counter write and an overflow. The second is a counter read and a count step. The bench aligns a rising edge on evtIn so that the count step lands exactly on the clock edge where the write or read strobe is held. The counter is preset to 0xFF for the write case, so that step overflows. For the write case, the bench judges that the counter reloads the old reload value and that the new value appears only at the following overflow. For the read case, it judges that the counter keeps its value through that step and that a later unread edge still counts.

// File: rtl/multiTimerPkg.sv
package multiTimerPkg;
  // Control byte field positions (decoded by the control unit)
  localparam int PSC_LO   = 0;
  localparam int PSC_W    = 3;
  localparam int EDGE_BIT = 3;
  localparam int RUN_BIT  = 4;
  localparam int RSV_BIT  = 5;
  localparam int MODE_LO  = 6;
  localparam int CTL_W    = 8;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_EVT  = 2'b01,
    MODE_TMR  = 2'b10,
    MODE_PWM  = 2'b11
  } tmrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic countEn;   // step the counter this cycle
    logic writePre;  // load reload register from write data
    logic writeCnt;  // load counter from write data (stopped only)
  } tmrStrobe_t;
endpackage

// File: rtl/multiTimerCtrl.sv
module multiTimerCtrl
  import multiTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             cntWrEn,
  input  logic             cntRdEn,
  input  logic             evtIn,
  output logic [CTL_W-1:0] ctlReg,
  output tmrStrobe_t       strobe
);
  localparam int DIV_W = 2 ** PSC_W;

  // Input synchronizer and edge detect
  logic [SYNC_STAGES-1:0] syncQ;
  logic evtPrev, evtLvl, evtRise, evtFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      evtPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], evtIn};
      evtPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign evtLvl  = syncQ[SYNC_STAGES-1];
  assign evtRise = evtLvl & ~evtPrev;
  assign evtFall = ~evtLvl & evtPrev;

  // Free-running prescaler with one tick tap per divide setting
  logic [DIV_W-1:0] preDiv;
  logic [DIV_W-1:0] tickVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preDiv <= '0;
    else       preDiv <= preDiv + 1'b1;
  end

  for (genvar i = 0; i < DIV_W; i++) begin : g_tap
    assign tickVec[i] = &preDiv[i:0];
  end

  // Field decode
  tmrMode_e mode;
  logic [PSC_W-1:0] pscSel;
  logic edgeSel, runBit, tick;

  assign mode    = tmrMode_e'(ctlReg[MODE_LO +: 2]);
  assign pscSel  = ctlReg[PSC_LO +: PSC_W];
  assign edgeSel = ctlReg[EDGE_BIT];
  assign runBit  = ctlReg[RUN_BIT];
  assign tick    = tickVec[pscSel];

  // Pulse-width measurement state
  logic measuring;
  logic startEdge, stopEdge, hwClr, cntStep;

  always_comb begin
    startEdge = edgeSel ? evtRise : evtFall;
    stopEdge  = edgeSel ? evtFall : evtRise;
    hwClr     = (mode == MODE_PWM) && runBit && measuring && stopEdge;
    unique case (mode)
      MODE_EVT: cntStep = runBit && (edgeSel ? evtFall : evtRise);
      MODE_TMR: cntStep = runBit && tick;
      MODE_PWM: cntStep = runBit && measuring && tick;
      default:  cntStep = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      measuring <= 1'b0;
    end else if (!runBit || mode != MODE_PWM) begin
      measuring <= 1'b0;
    end else if (!measuring && startEdge) begin
      measuring <= 1'b1;
    end else if (measuring && stopEdge) begin
      measuring <= 1'b0;
    end
  end

  // Control register: software write wins over hardware run clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg <= '0;
    end else if (ctlWrEn) begin
      ctlReg          <= ctlWrData;
      ctlReg[RSV_BIT] <= 1'b0;
    end else if (hwClr) begin
      ctlReg[RUN_BIT] <= 1'b0;
    end
  end

  always_comb begin
    strobe.countEn  = cntStep && !cntRdEn;
    strobe.writePre = cntWrEn;
    strobe.writeCnt = cntWrEn && !runBit;
  end
endmodule

// File: rtl/multiTimerDatapath.sv
module multiTimerDatapath
  import multiTimerPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             intEnable,
  output logic [CNT_W-1:0] count,
  output logic             intReq,
  output logic             wakeStrobe,
  output logic             divOut
);
  logic [CNT_W-1:0] preload;
  logic             overflow;

  assign overflow = strobe.countEn && (count == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preload <= '0;
    else if (strobe.writePre) preload <= cntWrData;
  end

  // Reload uses the value held before any same-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (overflow)        count <= preload;
    else if (strobe.writeCnt) count <= cntWrData;
    else if (strobe.countEn)  count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReq     <= 1'b0;
      wakeStrobe <= 1'b0;
      divOut     <= 1'b0;
    end else begin
      intReq     <= overflow && intEnable;
      wakeStrobe <= overflow;
      divOut     <= divOut ^ overflow;
    end
  end
endmodule

// File: rtl/multiTimer.sv
module multiTimer
  import multiTimerPkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             cntRdEn,
  input  logic             evtIn,
  input  logic             intEnable,
  output logic [7:0]       ctlRdData,
  output logic [CNT_W-1:0] cntRdData,
  output logic             intReq,
  output logic             wakeStrobe,
  output logic             divOut
);
  tmrStrobe_t strobe;

  multiTimerCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctlWrEn   (ctlWrEn),
    .ctlWrData (ctlWrData),
    .cntWrEn   (cntWrEn),
    .cntRdEn   (cntRdEn),
    .evtIn     (evtIn),
    .ctlReg    (ctlRdData),
    .strobe    (strobe)
  );

  multiTimerDatapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cntWrData  (cntWrData),
    .intEnable  (intEnable),
    .count      (cntRdData),
    .intReq     (intReq),
    .wakeStrobe (wakeStrobe),
    .divOut     (divOut)
  );
endmodule

// File: rtl/multiTimerChk.sv
module multiTimerChk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWrEn,
  input logic             cntWrEn,
  input logic             cntRdEn,
  input logic             intEnable,
  input logic [7:0]       ctlRdData,
  input logic [CNT_W-1:0] cntRdData,
  input logic             intReq,
  input logic             wakeStrobe,
  input logic             divOut
);
  p_int_needs_wake_r7: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> wakeStrobe);

  p_int_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    wakeStrobe |-> (intReq == $past(intEnable)));

  p_div_toggle_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakeStrobe |-> (divOut != $past(divOut)));

  p_div_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wakeStrobe |-> $stable(divOut));

  p_run_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdData[7:6] != 2'b11 && !ctlWrEn) |=> $stable(ctlRdData[4]));

  p_read_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cntRdEn && !cntWrEn) |=> $stable(cntRdData));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRdData[7:6] == 2'b00 && !cntWrEn) |=> $stable(cntRdData));
endmodule

bind multiTimer multiTimerChk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ctlWrEn    (ctlWrEn),
  .cntWrEn    (cntWrEn),
  .cntRdEn    (cntRdEn),
  .intEnable  (intEnable),
  .ctlRdData  (ctlRdData),
  .cntRdData  (cntRdData),
  .intReq     (intReq),
  .wakeStrobe (wakeStrobe),
  .divOut     (divOut)
);

// File: tb/sim_multiTimer.sv
`timescale 1ns/1ps
module sim_multiTimer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic       cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic       cntRdEn = 1'b0;
  logic       evtIn = 1'b0;
  logic       intEnable = 1'b0;
  logic [7:0] ctlRdData, cntRdData;
  logic       intReq, wakeStrobe, divOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  multiTimer u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .cntWrEn(cntWrEn), .cntWrData(cntWrData), .cntRdEn(cntRdEn),
    .evtIn(evtIn), .intEnable(intEnable), .ctlRdData(ctlRdData),
    .cntRdData(cntRdData), .intReq(intReq), .wakeStrobe(wakeStrobe),
    .divOut(divOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic ctlWrite(input logic [7:0] d);
    @(negedge clk); ctlWrEn = 1'b1; ctlWrData = d;
    @(negedge clk); ctlWrEn = 1'b0;
  endtask

  task automatic cntWrite(input logic [7:0] d);
    @(negedge clk); cntWrEn = 1'b1; cntWrData = d;
    @(negedge clk); cntWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Change evtIn; hold optional read/write strobes in the cycle whose
  // closing edge is the one that applies a count step (third edge).
  task automatic edgeWithSide(input logic lvl, input bit doRd, input bit doWr,
                              input logic [7:0] d);
    @(negedge clk); evtIn = lvl;
    @(negedge clk);
    @(negedge clk); cntRdEn = doRd; cntWrEn = doWr; cntWrData = d;
    @(negedge clk); cntRdEn = 1'b0; cntWrEn = 1'b0;
  endtask

  task automatic waitWake(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
    end while (!wakeStrobe && cyc < 5000);
  endtask

  task automatic testReset();
    chk("R1 ctl", ctlRdData, 8'h00);
    chk("R1 cnt", cntRdData, 8'h00);
    chk("R1 outs", {intReq, wakeStrobe, divOut}, 3'b000);
  endtask

  task automatic testCtlReg();
    ctlWrite(8'h2F);
    chk("R2 bit5 reads 0", ctlRdData, 8'h0F);
    ctlWrite(8'h00);
  endtask

  task automatic testTimer(input logic [2:0] n, input logic [7:0] p, input bit ien);
    int t0, t1;
    logic d0;
    intEnable = ien;
    ctlWrite(8'h00);
    cntWrite(p);
    ctlWrite(8'h90 | n);
    waitWake(t0);
    d0 = divOut;
    chk("R7 reload value", cntRdData, p);
    chk("R7 intReq gating", intReq, ien);
    waitWake(t1);
    chk("R3 overflow interval", t1, (256 - p) << (n + 1));
    chk("R10 divOut toggled", divOut, !d0);
    chk("R6 run kept", ctlRdData[4], 1'b1);
    ctlWrite(8'h00);
  endtask

  task automatic testEvent();
    ctlWrite(8'h00);
    cntWrite(8'h10);
    ctlWrite(8'h50);               // event, rising
    evtIn = 1'b1; idle(5);
    chk("R4 rising counted", cntRdData, 8'h11);
    evtIn = 1'b0; idle(5);
    chk("R4 falling ignored", cntRdData, 8'h11);
    ctlWrite(8'h58);               // event, falling
    evtIn = 1'b1; idle(5);
    chk("R4 rising ignored", cntRdData, 8'h11);
    evtIn = 1'b0; idle(5);
    chk("R4 falling counted", cntRdData, 8'h12);
    cntWrite(8'hFE);
    chk("R8 running write keeps count", cntRdData, 8'h12);
    ctlWrite(8'h40);               // stopped
    cntWrite(8'hFF);
    chk("R8 stopped write loads count", cntRdData, 8'hFF);
    ctlWrite(8'h50);
    evtIn = 1'b1; idle(5);
    chk("R8 reload from stopped write", cntRdData, 8'hFF);
    evtIn = 1'b0; idle(2);
  endtask

  task automatic testIdleMode();
    ctlWrite(8'h00);
    cntWrite(8'h33);
    ctlWrite(8'h10);               // mode 00, run set
    evtIn = 1'b1; idle(30);
    evtIn = 1'b0; idle(30);
    chk("R11 idle mode holds", cntRdData, 8'h33);
    ctlWrite(8'h00);
  endtask

  task automatic testPulse();
    ctlWrite(8'h00);
    cntWrite(8'h00);
    evtIn = 1'b1; idle(5);
    ctlWrite(8'hD8);               // pulse width, rising start, /2
    idle(20);
    chk("R5 level does not start", cntRdData, 8'h00);
    evtIn = 1'b0; idle(10);
    chk("R5 falling not a start", cntRdData, 8'h00);
    chk("R5 run still set", ctlRdData[4], 1'b1);
    evtIn = 1'b1; idle(40);
    evtIn = 1'b0; idle(10);
    chkRange("R5 pulse count", cntRdData, 19, 21);
    chk("R5 run cleared by hw", ctlRdData[4], 1'b0);
    begin
      logic [7:0] held = cntRdData;
      evtIn = 1'b1; idle(20); evtIn = 1'b0; idle(10);
      chk("R5 count holds after stop", cntRdData, held);
    end
    // falling-start variant
    ctlWrite(8'h00);
    cntWrite(8'h00);
    evtIn = 1'b1; idle(5);
    ctlWrite(8'hD0);
    evtIn = 1'b0; idle(20);
    evtIn = 1'b1; idle(10);
    chkRange("R5 low pulse count", cntRdData, 9, 11);
    chk("R5 run cleared low pulse", ctlRdData[4], 1'b0);
    evtIn = 1'b0; idle(5);
  endtask

  task automatic testReadGate();
    ctlWrite(8'h00);
    cntWrite(8'h20);
    ctlWrite(8'h50);
    edgeWithSide(1'b1, 1'b1, 1'b0, 8'h00);
    chk("R9 read blocks step", cntRdData, 8'h20);
    edgeWithSide(1'b0, 1'b0, 1'b0, 8'h00);
    edgeWithSide(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R9 unread edge counts", cntRdData, 8'h21);
    evtIn = 1'b0; idle(5);
  endtask

  task automatic testWriteOverflow();
    ctlWrite(8'h00);
    cntWrite(8'hFF);
    ctlWrite(8'h50);
    intEnable = 1'b1;
    edgeWithSide(1'b1, 1'b0, 1'b1, 8'h40);
    chk("R12 wake on overflow", wakeStrobe, 1'b1);
    chk("R12 old reload used", cntRdData, 8'hFF);
    edgeWithSide(1'b0, 1'b0, 1'b0, 8'h00);
    edgeWithSide(1'b1, 1'b0, 1'b0, 8'h00);
    chk("R12 new reload next overflow", cntRdData, 8'h40);
    evtIn = 1'b0; idle(5);
    ctlWrite(8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    testReset();
    @(negedge clk); rstN = 1'b1;
    idle(2);
    testReset();
    testCtlReg();
    testTimer(3'd0, 8'hFC, 1'b1);
    testTimer(3'd2, 8'hFE, 1'b0);
    testTimer(3'd7, 8'hFF, 1'b1);
    testEvent();
    testIdleMode();
    testPulse();
    testReadGate();
    testWriteOverflow();
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule